// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the control front end of a NOR-style flash device, modelled on one synchronous clock. It decodes three chip-select pins, an active-low output enable, an active-low write enable and an active-low reset/power-down pin. It holds a small internal word array and keeps track of which of four read views the data bus presents: array contents, a query word, identifier codes or the status register. Program and erase run on an internal write engine. Each takes a fixed number of clocks, and a busy flag is shown both in status bit 7 and on a status pin.

Host logic writes single-byte commands on the low byte of the data input while the device is selected. A two-write sequence starts a word program or a full-array erase. While the reset pin is low the device is deselected and the write engine is aborted. After reset is released, a command hold-off count and a read hold-off count keep the device quiet until they have run out.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the reset pin is released the read view is the array, and the status word reads 0x0080 once the write engine is idle.
- R2: Command bytes select the read view: 0xFF array (word at the address), 0x98 query (upper byte 0x51, lower byte the address), 0x90 identifier (address bit 0 clear gives 0x0089, set gives 0x0014), 0x70 status (bit 7 is the ready flag, all other bits 0).
- R3: `dq_oe` is 1 only when all three chip selects are low, output enable is low, write enable is high, reset is high and the read hold-off has run out. It is 0 otherwise, which means high impedance.
- R4: A write is taken on the clock where the device is selected, write enable is low and write enable was high on the previous clock. Writes made while the engine is busy, writes made while the device is deselected, and unknown command bytes all leave the read view unchanged.
- R5: The byte 0x40 followed by a data write programs the word at that write's address to old AND new. The engine stays busy for PROG_CYCLES clocks and the view switches to status.
- R6: The byte 0x20 followed by 0xD0 sets every word to 0xFFFF after ERASE_CYCLES busy clocks. Any other second byte cancels the sequence and selects the array view.
- R7: `sts` is low while reset is low, while the command hold-off is running and while the engine is busy. It is high otherwise.
- R8: Deselecting the device during a program does not stop the operation, and the data bus stays released while the device is deselected.
- R9: Pulling reset low during a program aborts it, so the array word keeps its old value. After release the status word reads 0x0080.
- R10: After release, a write whose strobe clock is within the first WAKE_CMD clocks is ignored. A write on the next clock after that is accepted.
- R11: After release, `dq_oe` stays 0 for WAKE_READ clocks and goes high on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rp_n | input | 1 | Reset/power-down, active low, asynchronous |
| ce | input | 3 | Chip-select pins; all low selects the device |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Word address |
| dq_in | input | DW | Data bus input (command byte in bits 7:0) |
| dq_out | output | DW | Data bus output value |
| dq_oe | output | 1 | Drive enable for the data bus |
| sts | output | 1 | Ready pin, low while busy or in reset |

## Verification
Random program sequences at random addresses with random data are checked against a bench model that ANDs each new word into the old one. This separates a true flash program from a plain overwrite. Random combinations of chip-select and output-enable levels are checked against the expected drive enable, which exposes wrong decoding of any one pin. Directed sequences cover three things. The first is the exact clock on which busy ends and each hold-off expires, which detects off-by-one counts. The second is writes made while busy, while deselected or with unknown bytes, which detects commands that leak through. The third is reset or deselection in the middle of a program, which separates an abort from a completion.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [1:0] {
      VIEW_ARRAY,
      VIEW_QUERY,
      VIEW_IDENT,
      VIEW_STATUS
   } rd_view_e;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_PROG,
      SEQ_ERASE
   } seq_e;

   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_PROG    = 8'h40;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;

endpackage

// File: rtl/flash_ce_decode.sv
module flash_ce_decode #(
   parameter int              NCE       = 3,
   parameter logic [NCE-1:0]  ACT_LEVEL = '0
) (
   input  logic [NCE-1:0] ce,
   output logic           sel
);

   logic [NCE-1:0] hit;

   generate
      for (genvar i = 0; i < NCE; i++) begin : g_pin
         if (ACT_LEVEL[i]) begin : g_high
            assign hit[i] = ce[i];
         end else begin : g_low
            assign hit[i] = ~ce[i];
         end
      end
   endgenerate

   assign sel = &hit;

endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
   parameter int AW           = 6,
   parameter int DW           = 16,
   parameter int PROG_CYCLES  = 8,
   parameter int ERASE_CYCLES = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_prog,
   input  logic          start_erase,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          busy,
   output logic          commit_prog,
   output logic          commit_erase,
   output logic [AW-1:0] commit_addr,
   output logic [DW-1:0] commit_data
);

   localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   generate
      if (PROG_CYCLES < 2 || ERASE_CYCLES < 2) begin : g_bad_cycles
         $error("flash_wsm: busy counts must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          is_erase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         cnt         <= '0;
         is_erase    <= 1'b0;
         commit_addr <= '0;
         commit_data <= '0;
      end else if (!busy) begin
         if (start_erase) begin
            busy     <= 1'b1;
            is_erase <= 1'b1;
            cnt      <= CW'(ERASE_CYCLES);
         end else if (start_prog) begin
            busy        <= 1'b1;
            is_erase    <= 1'b0;
            cnt         <= CW'(PROG_CYCLES);
            commit_addr <= addr_in;
            commit_data <= data_in;
         end
      end else if (cnt == CW'(1)) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign commit_prog  = busy && (cnt == CW'(1)) && !is_erase;
   assign commit_erase = busy && (cnt == CW'(1)) && is_erase;

   // R5
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_prog || start_erase) && !busy) |=> busy);

   // R6
   finish_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(commit_prog || commit_erase));

endmodule

// File: rtl/flash_array.sv
module flash_array #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          wr_prog,
   input  logic          wr_erase,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_erase) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i] <= '1;
         end
      end else if (wr_prog) begin
         mem[wr_addr] <= mem[wr_addr] & wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int          AW           = 6,
   parameter int          DW           = 16,
   parameter int          PROG_CYCLES  = 8,
   parameter int          ERASE_CYCLES = 20,
   parameter int          WAKE_CMD     = 4,
   parameter int          WAKE_READ    = 6,
   parameter logic [15:0] MFR_CODE     = 16'h0089,
   parameter logic [15:0] DEV_CODE     = 16'h0014,
   parameter logic [7:0]  QUERY_TAG    = 8'h51
) (
   input  logic          clk,
   input  logic          rp_n,
   input  logic [2:0]    ce,
   input  logic          oe_n,
   input  logic          we_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe,
   output logic          sts
);

   localparam int CCW = $clog2(WAKE_CMD + 1);
   localparam int RCW = $clog2(WAKE_READ + 1);

   generate
      if (DW < 16) begin : g_bad_dw
         $error("flash_cmd_ctrl: DW must be at least 16");
      end
      if (WAKE_CMD < 1 || WAKE_READ < 1) begin : g_bad_wake
         $error("flash_cmd_ctrl: wake counts must be at least 1");
      end
   endgenerate

   logic           ce_sel;
   logic           we_q;
   logic [CCW-1:0] cmd_cnt;
   logic [RCW-1:0] rd_cnt;
   rd_view_e       view;
   seq_e           seq;
   logic           busy;
   logic           wr_stb;
   logic           take;
   logic [7:0]     op;
   logic           start_prog;
   logic           start_erase;
   logic           commit_prog;
   logic           commit_erase;
   logic [AW-1:0]  commit_addr;
   logic [DW-1:0]  commit_data;
   logic [DW-1:0]  arr_word;

   flash_ce_decode #(.NCE(3), .ACT_LEVEL(3'b000)) u_ce (
      .ce  (ce),
      .sel (ce_sel)
   );

   flash_wsm #(
      .AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_wsm (
      .clk          (clk),
      .rst_n        (rp_n),
      .start_prog   (start_prog),
      .start_erase  (start_erase),
      .addr_in      (addr),
      .data_in      (dq_in),
      .busy         (busy),
      .commit_prog  (commit_prog),
      .commit_erase (commit_erase),
      .commit_addr  (commit_addr),
      .commit_data  (commit_data)
   );

   flash_array #(.AW(AW), .DW(DW)) u_arr (
      .clk      (clk),
      .rd_addr  (addr),
      .rd_data  (arr_word),
      .wr_prog  (commit_prog),
      .wr_erase (commit_erase),
      .wr_addr  (commit_addr),
      .wr_data  (commit_data)
   );

   assign op          = dq_in[7:0];
   assign wr_stb      = ce_sel && !we_n && we_q && (cmd_cnt == '0);
   assign take        = wr_stb && !busy;
   assign start_prog  = take && (seq == SEQ_PROG);
   assign start_erase = take && (seq == SEQ_ERASE) && (op == OP_CONFIRM);

   always_ff @(posedge clk or negedge rp_n) begin
      if (!rp_n) begin
         we_q    <= 1'b1;
         cmd_cnt <= CCW'(WAKE_CMD);
         rd_cnt  <= RCW'(WAKE_READ);
      end else begin
         we_q <= we_n;
         if (cmd_cnt != '0) cmd_cnt <= cmd_cnt - 1'b1;
         if (rd_cnt != '0)  rd_cnt  <= rd_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rp_n) begin
      if (!rp_n) begin
         view <= VIEW_ARRAY;
         seq  <= SEQ_IDLE;
      end else if (take) begin
         case (seq)
            SEQ_PROG: begin
               view <= VIEW_STATUS;
               seq  <= SEQ_IDLE;
            end
            SEQ_ERASE: begin
               view <= (op == OP_CONFIRM) ? VIEW_STATUS : VIEW_ARRAY;
               seq  <= SEQ_IDLE;
            end
            default: begin
               case (op)
                  OP_ARRAY:  view <= VIEW_ARRAY;
                  OP_QUERY:  view <= VIEW_QUERY;
                  OP_IDENT:  view <= VIEW_IDENT;
                  OP_STATUS: view <= VIEW_STATUS;
                  OP_PROG:   seq  <= SEQ_PROG;
                  OP_ERASE:  seq  <= SEQ_ERASE;
                  default:   ;
               endcase
            end
         endcase
      end
   end

   always_comb begin
      case (view)
         VIEW_QUERY:  dq_out = DW'({QUERY_TAG, 8'(addr)});
         VIEW_IDENT:  dq_out = DW'(addr[0] ? DEV_CODE : MFR_CODE);
         VIEW_STATUS: dq_out = DW'({!busy, 7'b0});
         default:     dq_out = arr_word;
      endcase
   end

   assign dq_oe = rp_n && ce_sel && !oe_n && we_n && (rd_cnt == '0);
   assign sts   = rp_n && !busy && (cmd_cnt == '0);

   // R3
   oe_release_chk: assert property (@(posedge clk) disable iff (!rp_n)
      (oe_n || !we_n || ce != 3'b000) |-> !dq_oe);

   // R7
   sts_busy_chk: assert property (@(posedge clk) disable iff (!rp_n)
      busy |-> !sts);

   // R2
   status_bit_chk: assert property (@(posedge clk) disable iff (!rp_n)
      (view == VIEW_STATUS) |-> (dq_out[7] == !busy));

   // R10
   wake_ignore_chk: assert property (@(posedge clk) disable iff (!rp_n)
      (ce_sel && !we_n && we_q && cmd_cnt != '0) |=> ($stable(view) && $stable(seq) && !busy));

endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;

   localparam int AW      = 6;
   localparam int DW      = 16;
   localparam int PROG_N  = 8;
   localparam int ERASE_N = 20;
   localparam int WAKE_C  = 4;
   localparam int WAKE_R  = 6;

   logic          clk   = 1'b0;
   logic          rp_n  = 1'b0;
   logic [2:0]    ce    = 3'b111;
   logic          oe_n  = 1'b1;
   logic          we_n  = 1'b1;
   logic [AW-1:0] addr  = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;
   logic          sts;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [15:0] model [64];

   always #5 clk = ~clk;

   flash_cmd_ctrl #(
      .AW(AW), .DW(DW), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N),
      .WAKE_CMD(WAKE_C), .WAKE_READ(WAKE_R)
   ) dut (
      .clk(clk), .rp_n(rp_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .sts(sts)
   );

   function automatic logic [15:0] f_query(input logic [AW-1:0] a);
      return {8'h51, 8'(a)};
   endfunction

   function automatic logic [15:0] f_ident(input logic [AW-1:0] a);
      return a[0] ? 16'h0014 : 16'h0089;
   endfunction

   function automatic logic [15:0] f_status(input bit ready);
      return ready ? 16'h0080 : 16'h0000;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_ce(input logic [2:0] c, input logic [AW-1:0] a, input logic [15:0] d);
      ce = c; addr = a; dq_in = d; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      wr_ce(3'b000, a, d);
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
      ce = 3'b000; addr = a; oe_n = 1'b0;
      #1;
      chk(dq_oe === 1'b1 && dq_out === exp, req, {15'b0, dq_oe, dq_out}, {15'b0, 1'b1, exp});
      oe_n = 1'b1;
   endtask

   task automatic reset_pulse();
      @(negedge clk);
      rp_n = 1'b0;
      repeat (3) @(negedge clk);
      rp_n = 1'b1;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a;
      logic [15:0]   d;
      void'($urandom(32'd2024));

      // reset state: bus released, sts low (R3, R7)
      repeat (3) @(negedge clk);
      ce = 3'b000; oe_n = 1'b0;
      #1;
      chk(dq_oe == 1'b0, "R3 reset", {31'b0, dq_oe}, 32'd0);
      chk(sts == 1'b0, "R7 reset", {31'b0, sts}, 32'd0);

      // read hold-off boundary (R11)
      @(negedge clk);
      rp_n = 1'b1;
      repeat (WAKE_R - 1) @(negedge clk);
      #1 chk(dq_oe == 1'b0, "R11 before", {31'b0, dq_oe}, 32'd0);
      @(negedge clk);
      #1 chk(dq_oe == 1'b1, "R11 after", {31'b0, dq_oe}, 32'd1);
      chk(sts == 1'b1, "R7 idle", {31'b0, sts}, 32'd1);
      oe_n = 1'b1;
      @(negedge clk);

      // status after release (R1)
      wr(0, 16'h0070);
      rd(0, f_status(1), "R1 status");

      // erase (R6)
      wr(0, 16'h0020);
      wr(0, 16'h00D0);
      chk(sts == 1'b0, "R6 busy", {31'b0, sts}, 32'd0);
      rd(0, f_status(0), "R6 busy status");
      repeat (ERASE_N) @(negedge clk);
      chk(sts == 1'b1, "R6 done", {31'b0, sts}, 32'd1);
      rd(5, f_status(1), "R6 status view");
      for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      wr(0, 16'h00FF);
      for (int i = 0; i < 6; i++) begin
         a = AW'($urandom);
         rd(a, 16'hFFFF, "R6 erased");
      end

      // erase cancel (R6)
      wr(0, 16'h0070);
      wr(0, 16'h0020);
      wr(0, 16'h0055);
      rd(3, 16'hFFFF, "R6 cancel view");
      chk(sts == 1'b1, "R6 cancel idle", {31'b0, sts}, 32'd1);

      // query and identifier views (R2)
      wr(0, 16'h0098);
      rd(0, f_query(0), "R2 query");
      rd(37, f_query(37), "R2 query");
      wr(0, 16'h0090);
      rd(0, f_ident(0), "R2 ident");
      rd(1, f_ident(1), "R2 ident");

      // unknown byte and deselected write ignored (R4)
      wr(0, 16'h0012);
      rd(2, f_ident(2), "R4 unknown");
      wr_ce(3'b101, 0, 16'h0098);
      rd(1, f_ident(1), "R4 deselected");

      // program with exact busy window (R5, R7)
      wr(0, 16'h00FF);
      wr(0, 16'h0040);
      wr(9, 16'hA5C3);
      model[9] = model[9] & 16'hA5C3;
      chk(sts == 1'b0, "R7 busy", {31'b0, sts}, 32'd0);
      repeat (PROG_N - 2) @(negedge clk);
      #1 chk(sts == 1'b0, "R7 last busy", {31'b0, sts}, 32'd0);
      @(negedge clk);
      #1 chk(sts == 1'b1, "R7 ready", {31'b0, sts}, 32'd1);
      rd(0, f_status(1), "R5 status view");
      wr(0, 16'h00FF);
      rd(9, model[9], "R5 program");

      // write during busy ignored (R4)
      wr(0, 16'h0040);
      wr(12, 16'h0F0F);
      model[12] = model[12] & 16'h0F0F;
      wr(0, 16'h00FF);
      repeat (PROG_N) @(negedge clk);
      rd(0, f_status(1), "R4 busy write");

      // random programs checked against AND model (R5)
      for (int i = 0; i < 12; i++) begin
         a = AW'($urandom);
         d = 16'($urandom);
         wr(0, 16'h0040);
         wr(a, d);
         model[a] = model[a] & d;
         repeat (PROG_N) @(negedge clk);
      end
      wr(0, 16'h00FF);
      rd(12, model[12], "R5 program");
      for (int i = 0; i < 16; i++) begin
         a = AW'($urandom);
         rd(a, model[a], "R5 random");
      end

      // random select/enable levels (R3)
      @(negedge clk);
      for (int i = 0; i < 24; i++) begin
         logic [2:0] c;
         logic       o;
         bit         exp_oe;
         c = 3'($urandom);
         o = 1'($urandom);
         a = AW'($urandom);
         ce = c; oe_n = o; addr = a;
         #1;
         exp_oe = (c == 3'b000) && (o == 1'b0);
         chk(dq_oe == exp_oe, "R3 enable", {31'b0, dq_oe}, {31'b0, exp_oe});
         if (exp_oe) chk(dq_out == model[a], "R3 data", {16'b0, dq_out}, {16'b0, model[a]});
         @(negedge clk);
      end
      ce = 3'b000; oe_n = 1'b0; dq_in = 16'h00FF; we_n = 1'b0;
      #1 chk(dq_oe == 1'b0, "R3 write low", {31'b0, dq_oe}, 32'd0);
      @(negedge clk);
      we_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);

      // deselect during program (R8)
      wr(0, 16'h0040);
      wr(20, 16'h3C3C);
      model[20] = model[20] & 16'h3C3C;
      ce = 3'b111; oe_n = 1'b0;
      #1 chk(dq_oe == 1'b0, "R8 released", {31'b0, dq_oe}, 32'd0);
      repeat (PROG_N) @(negedge clk);
      oe_n = 1'b1;
      chk(sts == 1'b1, "R8 completes", {31'b0, sts}, 32'd1);
      rd(0, f_status(1), "R8 status");
      wr(0, 16'h00FF);
      rd(20, model[20], "R8 program");

      // reset aborts program (R9, R1)
      wr(0, 16'h0040);
      wr(30, 16'h0000);
      repeat (2) @(negedge clk);
      rp_n = 1'b0;
      ce = 3'b000; oe_n = 1'b0;
      #1;
      chk(sts == 1'b0, "R9 sts", {31'b0, sts}, 32'd0);
      chk(dq_oe == 1'b0, "R9 released", {31'b0, dq_oe}, 32'd0);
      oe_n = 1'b1;
      repeat (PROG_N + 2) @(negedge clk);
      rp_n = 1'b1;
      repeat (WAKE_R + 1) @(negedge clk);
      rd(30, model[30], "R9 R1 array kept");
      wr(0, 16'h0070);
      rd(0, f_status(1), "R9 status 0080");

      // command hold-off boundary (R10)
      reset_pulse();
      repeat (WAKE_C - 1) @(negedge clk);
      wr(0, 16'h0070);
      repeat (WAKE_R) @(negedge clk);
      rd(7, model[7], "R10 ignored");
      reset_pulse();
      repeat (WAKE_C) @(negedge clk);
      wr(0, 16'h0070);
      repeat (WAKE_R) @(negedge clk);
      rd(7, f_status(1), "R10 accepted");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule